// File: doc/BRIEF.md
# USB Bus Idle and Reset Monitor

This block watches the decoded USB line state that a receiver delivers on every system clock cycle. It times runs of the idle J state and runs of SE0. A long enough idle run raises a suspend request. A long enough SE0 run raises a bus reset request. The two thresholds are 3 ms and 2.5 µs, and both are turned into cycle counts from a clock frequency parameter given in kHz. At 12 MHz these counts are 36000 and 30.

The suspend request stays set until the CPU performs any write strobe. The bus reset request follows the line: it drops on its own once SE0 ends. A suspend-mode flag is entered by a CPU pulse. While that flag is set, a K on the line is taken as resume, and a detected bus reset always raises its interrupt whatever the reset enable says. Both interrupt requests are single-cycle pulses. Clearing the USB enable input returns every counter and flag to zero.

Top module: `usb_line_monitor`

## Requirements
- R1: The line state encoding is 00 = SE0, 01 = J, 10 = K and 11 = invalid. `susp_req` becomes 1 at the clock edge that samples the SUSP_CYC-th consecutive J cycle. SUSP_CYC is the ceiling of CLK_KHZ*SUSPEND_US/1000.
- R2: A cycle with `cpu_wr`=1 clears `susp_req` at the next edge. If the threshold edge of R1 falls in the same cycle, the set wins.
- R3: `susp_req` is set at most once per J run. After it has been cleared it stays 0 until the line has left J and then completed a fresh full run.
- R4: `bus_rst_req` becomes 1 at the edge that samples the RST_CYC-th consecutive SE0 cycle. RST_CYC is the ceiling of CLK_KHZ*RESET_NS/1000000.
- R5: `bus_rst_req` returns to 0 at the first edge that samples a line state other than SE0. No CPU action is involved.
- R6: Any change of line state restarts both run counters. A J or SE0 run that is shorter than its threshold and is then interrupted sets nothing.
- R7: Outside suspend mode, `rst_irq` pulses high for exactly one cycle at the R4 detection edge, and only when `rst_ie`=1.
- R8: In suspend mode, reset detection pulses `rst_irq` whatever `rst_ie` is. The same edge clears `susp_mode`.
- R9: A `susp_enter` pulse sets `susp_mode`. A cycle that samples K while in suspend mode clears `susp_mode` at the next edge. If `rsm_ie`=1, that edge also pulses `rsm_irq` for one cycle.
- R10: While `usb_en`=0, all outputs are 0 at every edge and both run counters are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_en | input | 1 | Block enable; 0 clears all state |
| line_state | input | 2 | Decoded line state (00 SE0, 01 J, 10 K, 11 invalid) |
| cpu_wr | input | 1 | CPU write strobe; clears the suspend request |
| susp_enter | input | 1 | Pulse that enters suspend mode |
| rst_ie | input | 1 | Reset interrupt enable (outside suspend mode) |
| rsm_ie | input | 1 | Resume interrupt enable |
| susp_req | output | 1 | Suspend request flag |
| bus_rst_req | output | 1 | Bus reset request, follows SE0 |
| susp_mode | output | 1 | Suspend mode flag |
| rst_irq | output | 1 | Reset interrupt request pulse |
| rsm_irq | output | 1 | Resume interrupt request pulse |

## Verification
Two events can land in the same cycle: the CPU clear write for the suspend request and the idle threshold being reached. The bench provokes this by holding J for exactly SUSP_CYC-1 cycles and then asserting `cpu_wr` on the threshold cycle; the request must come out set. A second collision puts reset detection on a cycle where suspend mode is active. The bench judges it by checking, at that single edge, that the interrupt fires with `rst_ie`=0 and that suspend mode drops. Random line segments, including idle runs near the threshold, are compared cycle by cycle against a bench model written from the requirements.

// File: rtl/usb_lm_pkg.sv
package usb_lm_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_e;

    // ceiling division, never below one
    function automatic int unsigned ceil_div(input longint unsigned num,
                                             input longint unsigned den);
        longint unsigned q;
        q = (num + den - 1) / den;
        if (q == 0) q = 1;
        return int'(q);
    endfunction

endpackage

// File: rtl/usb_lm_run_timer.sv
module usb_lm_run_timer #(
    parameter int unsigned LIMIT = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic match,
    output logic hit,
    output logic held
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        hit = 1'b0;
        if (!enable || !match) begin
            s_d.cnt = '0;
        end else if (s_q.cnt < CW'(LIMIT)) begin
            s_d.cnt = s_q.cnt + 1'b1;
            hit     = (s_q.cnt == CW'(LIMIT - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign held = (s_q.cnt == CW'(LIMIT));

    // R1
    hit_then_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> held);

    // R6
    run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || !match) |=> !held);

endmodule

// File: rtl/usb_lm_event_ctrl.sv
module usb_lm_event_ctrl
    import usb_lm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] line,
    input  logic       cpu_wr,
    input  logic       enter,
    input  logic       rst_ie,
    input  logic       rsm_ie,
    input  logic       j_hit,
    input  logic       se_hit,
    output logic       susp_req,
    output logic       susp_mode,
    output logic       rst_irq,
    output logic       rsm_irq
);
    typedef struct packed {
        logic susp_req;
        logic mode;
        logic rst_irq;
        logic rsm_irq;
    } evt_t;

    evt_t s_d, s_q;
    logic resume;

    always_comb begin
        s_d    = s_q;
        resume = s_q.mode && (line == LS_K);
        if (!enable) begin
            s_d = '0;
        end else begin
            s_d.rst_irq = se_hit && (rst_ie || s_q.mode);
            s_d.rsm_irq = resume && rsm_ie;
            if (j_hit)       s_d.susp_req = 1'b1;
            else if (cpu_wr) s_d.susp_req = 1'b0;
            if (se_hit || resume) s_d.mode = 1'b0;
            else if (enter)       s_d.mode = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign susp_req  = s_q.susp_req;
    assign susp_mode = s_q.mode;
    assign rst_irq   = s_q.rst_irq;
    assign rsm_irq   = s_q.rsm_irq;

    // R2
    wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cpu_wr && !j_hit) |=> !susp_req);

    // R7
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_irq |=> !rst_irq);

    // R8
    susp_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && se_hit && susp_mode) |=> (rst_irq && !susp_mode));

    // R9
    rsm_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsm_irq |-> !susp_mode);

    // R10
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!susp_req && !susp_mode && !rst_irq && !rsm_irq));

endmodule

// File: rtl/usb_line_monitor.sv
module usb_line_monitor
    import usb_lm_pkg::*;
#(
    parameter int unsigned CLK_KHZ    = 12000,
    parameter int unsigned SUSPEND_US = 3000,
    parameter int unsigned RESET_NS   = 2500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       usb_en,
    input  logic [1:0] line_state,
    input  logic       cpu_wr,
    input  logic       susp_enter,
    input  logic       rst_ie,
    input  logic       rsm_ie,
    output logic       susp_req,
    output logic       bus_rst_req,
    output logic       susp_mode,
    output logic       rst_irq,
    output logic       rsm_irq
);
    localparam int unsigned SUSP_CYC =
        ceil_div(longint'(CLK_KHZ) * SUSPEND_US, 1000);
    localparam int unsigned RST_CYC  =
        ceil_div(longint'(CLK_KHZ) * RESET_NS, 1000000);

    logic j_hit, j_held, se_hit, se_held;

    usb_lm_run_timer #(.LIMIT(SUSP_CYC)) u_idle_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (usb_en),
        .match  (line_state == LS_J),
        .hit    (j_hit),
        .held   (j_held)
    );

    usb_lm_run_timer #(.LIMIT(RST_CYC)) u_se0_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (usb_en),
        .match  (line_state == LS_SE0),
        .hit    (se_hit),
        .held   (se_held)
    );

    usb_lm_event_ctrl u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (usb_en),
        .line      (line_state),
        .cpu_wr    (cpu_wr),
        .enter     (susp_enter),
        .rst_ie    (rst_ie),
        .rsm_ie    (rsm_ie),
        .j_hit     (j_hit),
        .se_hit    (se_hit),
        .susp_req  (susp_req),
        .susp_mode (susp_mode),
        .rst_irq   (rst_irq),
        .rsm_irq   (rsm_irq)
    );

    assign bus_rst_req = se_held;

    // R5
    rst_req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_req && line_state != LS_SE0) |=> !bus_rst_req);

    // R3
    one_set_per_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (j_held && line_state == LS_J && usb_en) |=> !$rose(susp_req));

endmodule

// File: tb/usb_line_monitor_test.sv
module usb_line_monitor_test;
    localparam int CLK_KHZ = 2000;
    localparam int SUSP    = (CLK_KHZ * 3000 + 999) / 1000;       // 6000
    localparam int RSTC    = (CLK_KHZ * 2500 + 999999) / 1000000; // 5
    localparam logic [1:0] SE0 = 2'b00, JS = 2'b01, KS = 2'b10, SE1 = 2'b11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic usb_en = 1'b0, cpu_wr = 1'b0, susp_enter = 1'b0;
    logic rst_ie = 1'b0, rsm_ie = 1'b0;
    logic [1:0] line_state = JS;
    logic susp_req, bus_rst_req, susp_mode, rst_irq, rsm_irq;

    int checks = 0, errors = 0, cycles = 0;

    int  m_j = 0, m_se = 0;
    bit  m_sreq = 0, m_mode = 0, m_rirq = 0, m_mirq = 0, m_breq = 0;

    always #4 clk = ~clk;

    usb_line_monitor #(.CLK_KHZ(CLK_KHZ)) uut (
        .clk(clk), .rst_n(rst_n), .usb_en(usb_en), .line_state(line_state),
        .cpu_wr(cpu_wr), .susp_enter(susp_enter), .rst_ie(rst_ie), .rsm_ie(rsm_ie),
        .susp_req(susp_req), .bus_rst_req(bus_rst_req), .susp_mode(susp_mode),
        .rst_irq(rst_irq), .rsm_irq(rsm_irq)
    );

    task automatic chk(input bit got, input bit exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    function automatic int run_next(input int cur, input bit match, input int lim);
        if (!match) return 0;
        return (cur < lim) ? cur + 1 : cur;
    endfunction

    // model update for one edge, following the requirements
    task automatic model_edge();
        bit jh, sh, resume;
        if (!usb_en) begin
            m_j = 0; m_se = 0;
            m_sreq = 0; m_mode = 0; m_rirq = 0; m_mirq = 0; m_breq = 0;
        end else begin
            jh = (line_state == JS) && (m_j == SUSP - 1);
            sh = (line_state == SE0) && (m_se == RSTC - 1);
            resume = m_mode && (line_state == KS);
            m_j  = run_next(m_j, line_state == JS, SUSP);
            m_se = run_next(m_se, line_state == SE0, RSTC);
            m_breq = (m_se >= RSTC);
            m_rirq = sh && (rst_ie || m_mode);
            m_mirq = resume && rsm_ie;
            if (jh) m_sreq = 1; else if (cpu_wr) m_sreq = 0;
            if (sh || resume) m_mode = 0; else if (susp_enter) m_mode = 1;
        end
    endtask

    task automatic step(input logic [1:0] ln, input bit wr, input bit ent);
        line_state = ln; cpu_wr = wr; susp_enter = ent;
        @(posedge clk);
        cycles++;
        model_edge();
        #2;
        chk(susp_req, m_sreq, "R1 model susp_req");
        chk(bus_rst_req, m_breq, "R4 model bus_rst_req");
        chk(rst_irq, m_rirq, "R7 model rst_irq");
        chk(rsm_irq, m_mirq, "R9 model rsm_irq");
        chk(susp_mode, m_mode, "R9 model susp_mode");
        cpu_wr = 0; susp_enter = 0;
    endtask

    task automatic hold(input logic [1:0] ln, input int n);
        for (int i = 0; i < n; i++) step(ln, 0, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cycles > 190000) begin
                errors++;
                $display("FAIL watchdog: got hung run expected completion");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4711));
        #20 rst_n = 1'b1;
        #2;
        // R10 reset state
        chk(susp_req | bus_rst_req | susp_mode | rst_irq | rsm_irq, 0, "R10 reset state");
        // R10 disabled: long J sets nothing
        hold(JS, SUSP + 5);
        chk(susp_req, 0, "R10 disabled idle");
        usb_en = 1'b1;

        // R1 threshold
        hold(KS, 1);
        hold(JS, SUSP - 1);
        chk(susp_req, 0, "R1 one cycle short");
        hold(JS, 1);
        chk(susp_req, 1, "R1 threshold reached");
        // R2 and R3
        hold(JS, 50);
        step(JS, 1, 0);
        chk(susp_req, 0, "R2 write clears");
        hold(JS, 300);
        chk(susp_req, 0, "R3 no second set in same run");
        // R2 collision: set wins
        hold(KS, 1);
        hold(JS, SUSP - 1);
        step(JS, 1, 0);
        chk(susp_req, 1, "R2 set wins over write");
        step(KS, 1, 0);
        chk(susp_req, 0, "R2 cleared after run");

        // R6 interrupted runs
        hold(SE0, RSTC - 1);
        hold(JS, 1);
        hold(SE0, RSTC - 1);
        chk(bus_rst_req, 0, "R6 interrupted SE0 run");
        hold(KS, 1);
        // R4 and R7 with rst_ie=0
        rst_ie = 0;
        hold(SE0, RSTC);
        chk(bus_rst_req, 1, "R4 reset detected");
        chk(rst_irq, 0, "R7 masked reset irq");
        hold(SE0, 3);
        chk(bus_rst_req, 1, "R4 held during SE0");
        step(JS, 0, 0);
        chk(bus_rst_req, 0, "R5 self clear");
        // R7 enabled
        rst_ie = 1;
        hold(SE0, RSTC);
        chk(rst_irq, 1, "R7 irq pulse");
        hold(SE0, 1);
        chk(rst_irq, 0, "R7 single cycle");
        hold(JS, 2);

        // R8 override in suspend
        rst_ie = 0;
        step(JS, 0, 1);
        chk(susp_mode, 1, "R9 enter suspend");
        hold(SE0, RSTC);
        chk(rst_irq, 1, "R8 irq while suspended");
        chk(susp_mode, 0, "R8 mode cleared");
        hold(JS, 2);
        // R9 resume
        rsm_ie = 1;
        step(JS, 0, 1);
        step(KS, 0, 0);
        chk(rsm_irq, 1, "R9 resume irq");
        chk(susp_mode, 0, "R9 resume clears mode");
        rsm_ie = 0;
        step(JS, 0, 1);
        step(KS, 0, 0);
        chk(rsm_irq, 0, "R9 masked resume");
        chk(susp_mode, 0, "R9 masked resume clears mode");

        // R10 disable clears flags
        hold(JS, SUSP);
        step(JS, 0, 1);
        chk(susp_req, 1, "R10 precondition");
        usb_en = 0;
        step(JS, 0, 0);
        chk(susp_req | susp_mode, 0, "R10 disable clears");
        usb_en = 1;

        // random segments
        for (int seg = 0; seg < 40 && cycles < 110000; seg++) begin
            int r, len;
            logic [1:0] ln;
            r = $urandom % 8;
            if (r < 3) begin
                ln = JS;
                len = ($urandom % 5 == 0) ? (SUSP - 10 + $urandom % 20) : (1 + $urandom % 50);
            end else if (r < 5) begin
                ln = KS; len = 1 + $urandom % 20;
            end else if (r < 7) begin
                ln = SE0; len = 1 + $urandom % (RSTC + 4);
            end else begin
                ln = SE1; len = 1 + $urandom % 4;
            end
            if ($urandom % 4 == 0) rst_ie = ~rst_ie;
            if ($urandom % 4 == 0) rsm_ie = ~rsm_ie;
            for (int i = 0; i < len; i++) begin
                usb_en = ($urandom % 3000 != 0);
                step(ln, ($urandom % 64) == 0, ($urandom % 100) == 0);
            end
            usb_en = 1;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule